// File: doc/BRIEF.md
# Butterfly dual add/subtract unit

This block is the add/subtract half of a radix-2 FFT butterfly. A single issued operation reads two operands from a sixteen-entry register file. It forms their sum and their difference at the same time, and writes the two results into two destination registers chosen by the operation. The operation word stays compact because the sources are restricted to two banks. The first operand always comes from registers 8 to 11 and the second always from registers 12 to 15, so each source is named by a 2-bit selector. An operation that marks its operands as taken in the swapped bank order is rejected: it raises a one-cycle illegal flag and changes no register.

Two arithmetic modes exist. Word mode treats each register as one 32-bit two's-complement value. Packed complex mode treats each register as a real half in bits [31:16] and an imaginary half in bits [15:0], and processes both halves in the same cycle as independent 16-bit integer lanes. A saturate input selects, for either mode, between wrap-around arithmetic and clamping of every lane to its signed range. A host write port loads registers and a combinational read port observes them.

Top module: `bfly_dual_addsub`

## Requirements
- R1: A valid, legal operation writes a+b into register dst_sum on the clock edge that samples it. The operation word is {valid[14], mode[13], dst_sum[12:9], dst_diff[8:5], src_a[4:3], src_b[2:1], bank_ok[0]}. In word mode (mode=0) without saturation, the sum wraps modulo 2^32.
- R2: On the same edge, the same operation writes a-b into register dst_diff, wrapping modulo 2^32 in word mode.
- R3: Operand a is register 8+src_a and operand b is register 12+src_b, for all sixteen selector combinations.
- R4: An operation with valid=1 and bank_ok=0 drives illegal high for exactly the one cycle after the edge that samples it and writes no register. A legal or idle cycle leaves illegal low.
- R5: In packed mode (mode=1), bits [31:16] and [15:0] are summed and differenced as separate 16-bit lanes that wrap modulo 2^16, with no carry or borrow between the halves.
- R6: With sat_en=1, each lane result is clamped to its signed range: 16 bits in packed mode and 32 bits in word mode. Positive overflow yields the maximum and negative overflow the minimum.
- R7: When dst_sum equals dst_diff, that register receives the difference.
- R8: An operation word with valid=0 changes no register and leaves illegal low.
- R9: Reset clears all sixteen registers and the illegal flag. host_we writes host_wdata into host_addr on the next edge. rd_data shows the register at rd_addr combinationally. A result of an operation takes precedence over a host write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_word | input | 15 | Operation word |
| sat_en | input | 1 | 1 = clamp lane results, 0 = wrap |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host write register index |
| host_wdata | input | 32 | Host write data |
| rd_addr | input | 4 | Read port register index |
| rd_data | output | 32 | Register contents at rd_addr |
| illegal | output | 1 | One-cycle flag for a rejected operation |

## Verification
The word-mode patterns include a positive operand that overflows into the sign bit. With saturation off this separates true modulo-2^32 wrapping from clamping, and with saturation on it shows both clamp directions. Packed operands are chosen so that the imaginary half carries out or borrows while the real half does not, which exposes any carry leaking between the lanes. A sweep of all sixteen source selectors over distinct register contents separates a correct bank offset from a swapped or shifted one. Overlapping destinations, swapped-order operations, idle words and host writes that collide with a result each check one write-priority rule, observed through the read port.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned RF_DEPTH   = 16;
  localparam int unsigned RF_AW      = $clog2(RF_DEPTH);
  localparam int unsigned BANK_SIZE  = RF_DEPTH / 4;
  localparam int unsigned SEL_W      = $clog2(BANK_SIZE);
  localparam int unsigned BANK_A_LO  = RF_DEPTH / 2;
  localparam int unsigned BANK_B_LO  = RF_DEPTH - BANK_SIZE;

  typedef enum logic {
    MODE_WORD   = 1'b0,
    MODE_PACKED = 1'b1
  } mode_e;

  typedef struct packed {
    logic             valid;
    logic             mode;
    logic [RF_AW-1:0] dst_sum;
    logic [RF_AW-1:0] dst_diff;
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic             bank_ok;
  } op_t;

  localparam int unsigned OP_W = $bits(op_t);
endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
  import bfly_pkg::*;
(
  input  logic [OP_W-1:0]  op_word,
  output logic             op_valid,
  output logic             mode_pk,
  output logic [RF_AW-1:0] dst_s,
  output logic [RF_AW-1:0] dst_d,
  output logic [RF_AW-1:0] idx_a,
  output logic [RF_AW-1:0] idx_b,
  output logic             issue_ok,
  output logic             issue_bad
);
  op_t op;

  always_comb begin
    op        = op_t'(op_word);
    op_valid  = op.valid;
    mode_pk   = (mode_e'(op.mode) == MODE_PACKED);
    dst_s     = op.dst_sum;
    dst_d     = op.dst_diff;
    idx_a     = RF_AW'(BANK_A_LO) + RF_AW'(op.src_a);
    idx_b     = RF_AW'(BANK_B_LO) + RF_AW'(op.src_b);
    issue_ok  = op.valid & op.bank_ok;
    issue_bad = op.valid & ~op.bank_ok;
  end
endmodule

// File: rtl/bfly_lane.sv
module bfly_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff
);
  function automatic logic [W:0] ext_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x[W-1], x} + {y[W-1], y};
  endfunction

  function automatic logic [W:0] ext_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x[W-1], x} - {y[W-1], y};
  endfunction

  function automatic logic [W-1:0] clip(input logic [W:0] e, input logic clamp);
    if (clamp && (e[W] != e[W-1]))
      return e[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return e[W-1:0];
  endfunction

  always_comb begin
    sum  = clip(ext_add(a, b), sat);
    diff = clip(ext_sub(a, b), sat);
  end
endmodule

// File: rtl/bfly_regfile.sv
module bfly_regfile #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [AW-1:0]           host_addr,
  input  logic [DATA_W-1:0]       host_data,
  input  logic                    we_s,
  input  logic [AW-1:0]           addr_s,
  input  logic [DATA_W-1:0]       data_s,
  input  logic                    we_d,
  input  logic [AW-1:0]           addr_d,
  input  logic [DATA_W-1:0]       data_d,
  output logic [DEPTH*DATA_W-1:0] rf_flat
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (we_d && addr_d == AW'(e))
        q <= data_d;
      else if (we_s && addr_s == AW'(e))
        q <= data_s;
      else if (host_we && host_addr == AW'(e))
        q <= host_data;
    end
    assign rf_flat[e*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/bfly_dual_addsub.sv
module bfly_dual_addsub
  import bfly_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_word,
  input  logic              sat_en,
  input  logic              host_we,
  input  logic [RF_AW-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [RF_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              illegal
);
  logic                       op_valid, mode_pk, issue_ok, issue_bad;
  logic [RF_AW-1:0]           dst_s, dst_d, idx_a, idx_b;
  logic [RF_DEPTH*DATA_W-1:0] rf_flat;
  logic [DATA_W-1:0]          opa, opb;
  logic [DATA_W-1:0]          w_sum, w_diff, p_sum, p_diff;
  logic [DATA_W-1:0]          sum_val, diff_val;

  function automatic logic [DATA_W-1:0] pick(input logic [RF_AW-1:0] i,
                                             input logic [RF_DEPTH*DATA_W-1:0] v);
    return v[i*DATA_W +: DATA_W];
  endfunction

  bfly_decode u_dec (
    .op_word   (op_word),
    .op_valid  (op_valid),
    .mode_pk   (mode_pk),
    .dst_s     (dst_s),
    .dst_d     (dst_d),
    .idx_a     (idx_a),
    .idx_b     (idx_b),
    .issue_ok  (issue_ok),
    .issue_bad (issue_bad)
  );

  bfly_regfile #(.DEPTH(RF_DEPTH), .DATA_W(DATA_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_data (host_wdata),
    .we_s      (issue_ok),
    .addr_s    (dst_s),
    .data_s    (sum_val),
    .we_d      (issue_ok),
    .addr_d    (dst_d),
    .data_d    (diff_val),
    .rf_flat   (rf_flat)
  );

  assign opa     = pick(idx_a, rf_flat);
  assign opb     = pick(idx_b, rf_flat);
  assign rd_data = pick(rd_addr, rf_flat);

  bfly_lane #(.W(DATA_W)) u_word (
    .a    (opa),
    .b    (opb),
    .sat  (sat_en),
    .sum  (w_sum),
    .diff (w_diff)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    bfly_lane #(.W(LANE_W)) u_pk (
      .a    (opa[l*LANE_W +: LANE_W]),
      .b    (opb[l*LANE_W +: LANE_W]),
      .sat  (sat_en),
      .sum  (p_sum[l*LANE_W +: LANE_W]),
      .diff (p_diff[l*LANE_W +: LANE_W])
    );
  end

  assign sum_val  = mode_pk ? p_sum  : w_sum;
  assign diff_val = mode_pk ? p_diff : w_diff;

  always_ff @(posedge clk) begin
    if (!rst_n) illegal <= 1'b0;
    else        illegal <= issue_bad;
  end
endmodule

// File: rtl/bfly_dual_addsub_chk.sv
module bfly_dual_addsub_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic                    issue_ok,
  input logic                    issue_bad,
  input logic                    host_we,
  input logic [AW-1:0]           dst_s,
  input logic [AW-1:0]           dst_d,
  input logic [DATA_W-1:0]       sum_val,
  input logic [DATA_W-1:0]       diff_val,
  input logic [DEPTH*DATA_W-1:0] rf_flat,
  input logic                    illegal
);
  function automatic logic [DATA_W-1:0] word_at(input logic [DEPTH*DATA_W-1:0] v,
                                                input logic [AW-1:0] i);
    return v[i*DATA_W +: DATA_W];
  endfunction

  a_r1_sum_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && dst_s != dst_d) |=> word_at(rf_flat, $past(dst_s)) == $past(sum_val));

  // R2 and R7: the difference always reaches dst_diff
  a_r7_diff_lands: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> word_at(rf_flat, $past(dst_d)) == $past(diff_val));

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    issue_bad |=> illegal);

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_bad |=> !illegal);

  a_r4_rf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_bad && !host_we) |=> $stable(rf_flat));

  a_r8_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !host_we) |=> $stable(rf_flat));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_ok && issue_bad));
endmodule

bind bfly_dual_addsub bfly_dual_addsub_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (bfly_pkg::RF_DEPTH),
  .AW     (bfly_pkg::RF_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .issue_ok  (issue_ok),
  .issue_bad (issue_bad),
  .host_we   (host_we),
  .dst_s     (dst_s),
  .dst_d     (dst_d),
  .sum_val   (sum_val),
  .diff_val  (diff_val),
  .rf_flat   (rf_flat),
  .illegal   (illegal)
);

// File: tb/bfly_dual_addsub_tb_top.sv
module bfly_dual_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] op_word = '0;
  logic        sat_en = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [16];
  logic ill_next, ill_later;

  always #4 clk = ~clk;

  bfly_dual_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .op_word(op_word), .sat_en(sat_en),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .illegal(illegal)
  );

  function automatic logic [14:0] mk_op(bit v, bit m, logic [3:0] ds, logic [3:0] dd,
                                        logic [1:0] sa, logic [1:0] sb, bit ok);
    return {v, m, ds, dd, sa, sb, ok};
  endfunction

  function automatic longint lane_calc(longint x, longint y, int w, bit sat, bit sub);
    longint r, hi, lo, m;
    r  = sub ? x - y : x + y;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (sat) begin
      if (r > hi) r = hi;
      if (r < lo) r = lo;
    end
    m = (longint'(1) <<< w) - 1;
    return r & m;
  endfunction

  function automatic logic [31:0] expect_val(logic [31:0] a, logic [31:0] b,
                                             bit packed_m, bit sat, bit sub);
    logic [31:0] r;
    if (packed_m) begin
      r[31:16] = 16'(lane_calc(longint'($signed(a[31:16])), longint'($signed(b[31:16])), 16, sat, sub));
      r[15:0]  = 16'(lane_calc(longint'($signed(a[15:0])),  longint'($signed(b[15:0])),  16, sat, sub));
    end else begin
      r = 32'(lane_calc(longint'($signed(a)), longint'($signed(b)), 32, sat, sub));
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int a);
    @(negedge clk);
    rd_addr = 4'(a);
    #1;
    check(req, rd_data, model[a]);
  endtask

  task automatic host_wr(int a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model[a] = d;
  endtask

  // issue one op; update model; capture illegal in the cycle after and the one after that
  task automatic issue(bit m, bit sat, int ds, int dd, int sa, int sb, bit ok);
    logic [31:0] a, b;
    a = model[8 + sa];
    b = model[12 + sb];
    @(negedge clk);
    op_word = mk_op(1'b1, m, 4'(ds), 4'(dd), 2'(sa), 2'(sb), ok);
    sat_en  = sat;
    @(negedge clk);
    op_word = '0;
    ill_next = illegal;
    @(negedge clk);
    ill_later = illegal;
    sat_en = 1'b0;
    if (ok) begin
      model[ds] = expect_val(a, b, m, sat, 1'b0);
      model[dd] = expect_val(a, b, m, sat, 1'b1);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) model[i] = '0;
    chk_reg("R9 reset reg0", 0);
    chk_reg("R9 reset reg8", 8);
    chk_reg("R9 reset reg15", 15);
    check("R9 reset illegal", 32'(illegal), 32'd0);
  endtask

  task automatic t_load();
    for (int i = 0; i < 16; i++) host_wr(i, 32'h1357_0000 + 32'(i * 32'h0101_0011));
    chk_reg("R9 host write reg5", 5);
    chk_reg("R9 host write reg13", 13);
  endtask

  task automatic t_word();
    host_wr(9, 32'h7FFF_FFFF);
    host_wr(14, 32'h0000_0001);
    issue(1'b0, 1'b0, 1, 2, 1, 2, 1'b1);
    chk_reg("R1 word sum wraps", 1);
    chk_reg("R2 word diff", 2);
    check("R4 legal op keeps illegal low", 32'(ill_next), 32'd0);
    host_wr(9, 32'h8000_0000);
    issue(1'b0, 1'b0, 1, 2, 1, 2, 1'b1);
    chk_reg("R1 word sum negative", 1);
    chk_reg("R2 word diff borrow wraps", 2);
  endtask

  task automatic t_decode();
    for (int i = 8; i < 16; i++) host_wr(i, 32'h0F00_0000 + 32'(i * 32'h0003_0107));
    for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++) begin
        issue(1'b0, 1'b0, 0, 3, sa, sb, 1'b1);
        chk_reg("R3 source decode sum", 0);
        chk_reg("R3 source decode diff", 3);
      end
  endtask

  task automatic t_packed();
    host_wr(10, 32'h0001_FFFF);
    host_wr(13, 32'h0001_0001);
    issue(1'b1, 1'b0, 4, 5, 2, 1, 1'b1);
    chk_reg("R5 packed sum no carry", 4);
    check("R5 packed sum literal", model[4], 32'h0002_0000);
    chk_reg("R5 packed diff no borrow", 5);
    check("R5 packed diff literal", model[5], 32'h0000_FFFE);
  endtask

  task automatic t_sat();
    host_wr(8, 32'h7FFF_8000);
    host_wr(12, 32'h0001_0001);
    issue(1'b1, 1'b1, 6, 7, 0, 0, 1'b1);
    chk_reg("R6 packed sat sum", 6);
    check("R6 packed sat sum literal", model[6], 32'h7FFF_8001);
    chk_reg("R6 packed sat diff", 7);
    check("R6 packed sat diff literal", model[7], 32'h7FFE_8000);
    host_wr(8, 32'h7FFF_FFFF);
    issue(1'b0, 1'b1, 6, 7, 0, 0, 1'b1);
    chk_reg("R6 word sat max", 6);
    host_wr(8, 32'h8000_0000);
    issue(1'b0, 1'b1, 6, 7, 0, 0, 1'b1);
    chk_reg("R6 word sat min", 7);
    check("R6 word sat min literal", model[7], 32'h8000_0000);
  endtask

  task automatic t_same_dst();
    host_wr(11, 32'h0000_0100);
    host_wr(15, 32'h0000_0030);
    issue(1'b0, 1'b0, 3, 3, 3, 3, 1'b1);
    chk_reg("R7 same dst gets diff", 3);
    check("R7 literal", model[3], 32'h0000_00D0);
  endtask

  task automatic t_illegal();
    host_wr(4, 32'hAAAA_0004);
    host_wr(5, 32'h5555_0005);
    issue(1'b0, 1'b0, 4, 5, 1, 1, 1'b0);
    check("R4 illegal flag raised", 32'(ill_next), 32'd1);
    check("R4 illegal flag one cycle", 32'(ill_later), 32'd0);
    chk_reg("R4 dst_sum untouched", 4);
    chk_reg("R4 dst_diff untouched", 5);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_word = mk_op(1'b0, 1'b0, 4'd4, 4'd5, 2'd0, 2'd0, 1'b1);
    @(negedge clk);
    ill_next = illegal;
    op_word = mk_op(1'b0, 1'b1, 4'd4, 4'd5, 2'd1, 2'd1, 1'b0);
    @(negedge clk);
    op_word = '0;
    check("R8 idle illegal low", 32'(ill_next | illegal), 32'd0);
    chk_reg("R8 idle reg4 kept", 4);
    chk_reg("R8 idle reg5 kept", 5);
  endtask

  task automatic t_collide();
    logic [31:0] a, b;
    a = model[8]; b = model[12];
    @(negedge clk);
    op_word = mk_op(1'b1, 1'b0, 4'd2, 4'd1, 2'd0, 2'd0, 1'b1);
    host_we = 1'b1; host_addr = 4'd2; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    op_word = '0; host_we = 1'b0;
    model[2] = expect_val(a, b, 1'b0, 1'b0, 1'b0);
    model[1] = expect_val(a, b, 1'b0, 1'b0, 1'b1);
    chk_reg("R9 op wins over host write", 2);
    chk_reg("R2 diff alongside collision", 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_word();
    t_decode();
    t_packed();
    t_sat();
    t_same_dst();
    t_illegal();
    t_idle();
    t_collide();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule